// File: doc/BRIEF.md
# Double-Data-Rate Two-Word-Burst SRAM with Deferred Write Commit

This block is a synthesizable model of a pipelined synchronous SRAM whose data pins move one 18-bit word on each edge of a differential clock pair. The two edges of that pair are represented by one internal clock running at twice the pair's rate. A phase flag marks which edge comes next: a "K" edge, where commands are taken, or a "K#" edge, which only moves data. Every access transfers two words (36 bits) at a single line address. Separate data-in and data-out buses let a read and a write overlap.

A write's address is taken with its command. The two data words follow on the next K edge and the K# edge after it, each word with two active-low byte selects. A completed write line is not written to storage immediately. It waits in a single deferred-write register together with its byte enables. It is merged into storage only when the next write's data is complete. Reads always see the newest data: the read path overlays the deferred register on the stored line whenever the addresses match.

A read returns its first word two K periods after the command and its second word on the following K# edge. The output-enable flag is high only while those words are on the bus.

Top module: `ddr2w_sram`

## Requirements
- R1: While reset is asserted, `q_oe_o` is low and `k_phase_o` is high, so the first edge after reset release is a K edge.
- R2: Commands are taken only on K edges, and `k_phase_o` alternates on every clock edge after reset. A low `ld_n_i` on a K# edge has no effect, whether `rw_i` asks for a read or a write.
- R3: A read taken on K edge n drives word 0 (line bits [17:0]) after edge n+4 and word 1 (line bits [35:18]) after edge n+5. `q_oe_o` is high for exactly those two edges.
- R4: A write taken on K edge n captures word 0 from `d_i` at edge n+2 and word 1 at edge n+3.
- R5: Byte selects are active low and are sampled with each word. Bit 0 enables word bits [8:0] and bit 1 enables word bits [17:9]. A high select leaves that stored byte unchanged.
- R6: A new read or write may be issued on every K edge, so bursts run back to back with no idle edges.
- R7: A read issued on the K edge right after a write to the same address returns the new data.
- R8: A write still waiting in the deferred register, with reads issued after it, is returned by a later read of its address.
- R9: When no read is pending, `q_oe_o` goes low after the next K edge that follows the last word of a burst.
- R10: A deferred write is committed when the next write completes, and a later read of its address still returns its data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; edges alternate between K and K# |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_n_i | input | 1 | Load strobe, active low, sampled on K edges |
| rw_i | input | 1 | 1 = read, 0 = write, when the strobe is low |
| addr_i | input | ADDR_W | Line address, sampled with the command |
| d_i | input | 18 | Write data word |
| bw_n_i | input | 2 | Active-low byte selects for the current write word |
| k_phase_o | output | 1 | High when the coming edge is a K edge |
| q_o | output | 18 | Read data word |
| q_oe_o | output | 1 | Output enable; low means the data bus is released |

## Verification
The collision that matters is a read that meets a write that is still in flight to the same line. Three timings are covered: the write is in the deferred register, it is being committed to storage on the same pass, or a newer write is loading its data while the read's words are being fetched.

The bench provokes these by issuing a write immediately followed by a read of the same address. It also interleaves unrelated reads before re-reading a deferred address, and issues a second write straight after a read so that the commit falls inside the read's burst.

A queue-based reference, which applies each write at the edge its second word arrives and takes each read's line when its first word is due, judges every data word and every output-enable value edge by edge.

// File: rtl/ddr2w_pkg.sv
`timescale 1ns/1ps
package ddr2w_pkg;
  localparam int BYTE_W     = 9;
  localparam int WBYTES     = 2;
  localparam int WORD_W     = BYTE_W * WBYTES;
  localparam int LINE_BYTES = 2 * WBYTES;
  localparam int LINE_W     = BYTE_W * LINE_BYTES;

  typedef enum logic [1:0] {CMD_NOP, CMD_RD, CMD_WR} cmd_e;

  // Overlay the enabled bytes of new_l on old_l.
  function automatic logic [LINE_W-1:0] merge_line(
    input logic [LINE_W-1:0]     old_l,
    input logic [LINE_W-1:0]     new_l,
    input logic [LINE_BYTES-1:0] be
  );
    logic [LINE_W-1:0] r;
    r = old_l;
    for (int i = 0; i < LINE_BYTES; i++) begin
      if (be[i]) r[i*BYTE_W +: BYTE_W] = new_l[i*BYTE_W +: BYTE_W];
    end
    return r;
  endfunction
endpackage

// File: rtl/ddr2w_phase.sv
`timescale 1ns/1ps
module ddr2w_phase (
  input  logic clk,
  input  logic rst_n,
  output logic k_edge_o
);
  logic ph_q, ph_d;

  always_comb ph_d = ~ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  assign k_edge_o = ~ph_q;
endmodule

// File: rtl/ddr2w_wpath.sv
`timescale 1ns/1ps
module ddr2w_wpath
  import ddr2w_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  k_edge_i,
  input  logic                  wr_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [WORD_W-1:0]     d_i,
  input  logic [WBYTES-1:0]     bw_n_i,
  output logic                  post_v_o,
  output logic [ADDR_W-1:0]     post_a_o,
  output logic [LINE_W-1:0]     post_d_o,
  output logic [LINE_BYTES-1:0] post_be_o,
  output logic                  commit_o
);
  logic                  s1_v_q, s1_v_d, s2_v_q, s2_v_d, pv_q, pv_d;
  logic [ADDR_W-1:0]     s1_a_q, s1_a_d, s2_a_q, s2_a_d, pa_q, pa_d;
  logic [WORD_W-1:0]     w0_q, w0_d;
  logic [WBYTES-1:0]     w0_be_q, w0_be_d;
  logic [LINE_W-1:0]     pd_q, pd_d;
  logic [LINE_BYTES-1:0] pbe_q, pbe_d;

  always_comb begin
    s1_v_d = s1_v_q;  s1_a_d = s1_a_q;
    s2_v_d = s2_v_q;  s2_a_d = s2_a_q;
    w0_d   = w0_q;    w0_be_d = w0_be_q;
    pv_d   = pv_q;    pa_d = pa_q;  pd_d = pd_q;  pbe_d = pbe_q;
    if (k_edge_i) begin
      s1_v_d = wr_i;
      s1_a_d = addr_i;
      s2_v_d = s1_v_q;
      s2_a_d = s1_a_q;
      if (s1_v_q) begin
        w0_d    = d_i;
        w0_be_d = ~bw_n_i;
      end
    end else if (s2_v_q) begin
      pv_d  = 1'b1;
      pa_d  = s2_a_q;
      pd_d  = {d_i, w0_q};
      pbe_d = {~bw_n_i, w0_be_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v_q <= 1'b0;
      s2_v_q <= 1'b0;
      pv_q   <= 1'b0;
    end else begin
      s1_v_q <= s1_v_d;
      s2_v_q <= s2_v_d;
      pv_q   <= pv_d;
    end
  end

  always_ff @(posedge clk) begin
    s1_a_q  <= s1_a_d;
    s2_a_q  <= s2_a_d;
    w0_q    <= w0_d;
    w0_be_q <= w0_be_d;
    pa_q    <= pa_d;
    pd_q    <= pd_d;
    pbe_q   <= pbe_d;
  end

  assign commit_o  = !k_edge_i && s2_v_q && pv_q;
  assign post_v_o  = pv_q;
  assign post_a_o  = pa_q;
  assign post_d_o  = pd_q;
  assign post_be_o = pbe_q;
endmodule

// File: rtl/ddr2w_array.sv
`timescale 1ns/1ps
module ddr2w_array
  import ddr2w_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                  clk,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     wa_i,
  input  logic [LINE_W-1:0]     wd_i,
  input  logic [LINE_BYTES-1:0] wbe_i,
  input  logic [ADDR_W-1:0]     ra_i,
  input  logic                  byp_v_i,
  input  logic [ADDR_W-1:0]     byp_a_i,
  input  logic [LINE_W-1:0]     byp_d_i,
  input  logic [LINE_BYTES-1:0] byp_be_i,
  output logic [LINE_W-1:0]     rline_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LINE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[wa_i] <= merge_line(mem[wa_i], wd_i, wbe_i);
  end

  always_comb begin
    if (byp_v_i && (byp_a_i == ra_i)) rline_o = merge_line(mem[ra_i], byp_d_i, byp_be_i);
    else                              rline_o = mem[ra_i];
  end
endmodule

// File: rtl/ddr2w_rpath.sv
`timescale 1ns/1ps
module ddr2w_rpath
  import ddr2w_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              k_edge_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LINE_W-1:0] rline_i,
  output logic [ADDR_W-1:0] ra_o,
  output logic [WORD_W-1:0] q_o,
  output logic              q_oe_o
);
  logic              r1_v_q, r1_v_d, r2_v_q, r2_v_d, oe_q, oe_d;
  logic [ADDR_W-1:0] r1_a_q, r1_a_d, r2_a_q, r2_a_d;
  logic [WORD_W-1:0] q_q, q_d, hi_q, hi_d;

  always_comb begin
    r1_v_d = r1_v_q;  r1_a_d = r1_a_q;
    r2_v_d = r2_v_q;  r2_a_d = r2_a_q;
    oe_d   = oe_q;    q_d = q_q;  hi_d = hi_q;
    if (k_edge_i) begin
      r1_v_d = rd_i;
      r1_a_d = addr_i;
      r2_v_d = r1_v_q;
      r2_a_d = r1_a_q;
      oe_d   = r2_v_q;
      q_d    = r2_v_q ? rline_i[WORD_W-1:0] : '0;
      hi_d   = rline_i[LINE_W-1:WORD_W];
    end else if (oe_q) begin
      q_d = hi_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_v_q <= 1'b0;
      r2_v_q <= 1'b0;
      oe_q   <= 1'b0;
      q_q    <= '0;
    end else begin
      r1_v_q <= r1_v_d;
      r2_v_q <= r2_v_d;
      oe_q   <= oe_d;
      q_q    <= q_d;
    end
  end

  always_ff @(posedge clk) begin
    r1_a_q <= r1_a_d;
    r2_a_q <= r2_a_d;
    hi_q   <= hi_d;
  end

  assign ra_o   = r2_a_q;
  assign q_o    = q_q;
  assign q_oe_o = oe_q;
endmodule

// File: rtl/ddr2w_sram.sv
`timescale 1ns/1ps
module ddr2w_sram
  import ddr2w_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_n_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] d_i,
  input  logic [WBYTES-1:0] bw_n_i,
  output logic              k_phase_o,
  output logic [WORD_W-1:0] q_o,
  output logic              q_oe_o
);
  logic rs_meta, rs_n;
  logic k_edge;
  cmd_e cmd;
  logic                  post_v, commit;
  logic [ADDR_W-1:0]     post_a, ra;
  logic [LINE_W-1:0]     post_d, rline;
  logic [LINE_BYTES-1:0] post_be;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  ddr2w_phase u_phase (.clk(clk), .rst_n(rs_n), .k_edge_o(k_edge));

  always_comb begin
    cmd = CMD_NOP;
    if (k_edge && !ld_n_i) cmd = rw_i ? CMD_RD : CMD_WR;
  end

  ddr2w_wpath #(.ADDR_W(ADDR_W)) u_wpath (
    .clk(clk), .rst_n(rs_n), .k_edge_i(k_edge), .wr_i(cmd == CMD_WR),
    .addr_i(addr_i), .d_i(d_i), .bw_n_i(bw_n_i),
    .post_v_o(post_v), .post_a_o(post_a), .post_d_o(post_d),
    .post_be_o(post_be), .commit_o(commit)
  );

  ddr2w_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we_i(commit), .wa_i(post_a), .wd_i(post_d), .wbe_i(post_be),
    .ra_i(ra), .byp_v_i(post_v), .byp_a_i(post_a), .byp_d_i(post_d),
    .byp_be_i(post_be), .rline_o(rline)
  );

  ddr2w_rpath #(.ADDR_W(ADDR_W)) u_rpath (
    .clk(clk), .rst_n(rs_n), .k_edge_i(k_edge), .rd_i(cmd == CMD_RD),
    .addr_i(addr_i), .rline_i(rline), .ra_o(ra), .q_o(q_o), .q_oe_o(q_oe_o)
  );

  assign k_phase_o = k_edge;
endmodule

// File: rtl/ddr2w_sram_chk.sv
`timescale 1ns/1ps
module ddr2w_sram_chk (
  input logic clk,
  input logic rs_n,
  input logic k_phase_o,
  input logic q_oe_o,
  input logic post_v
);
  // R2: after release the phase flag flips on every edge
  assert_phase_alt_R2: assert property (@(posedge clk) disable iff (!rs_n)
    rs_n |=> (k_phase_o != $past(k_phase_o)));

  // R3: a first word on the bus is always followed by a second
  assert_burst_pair_R3: assert property (@(posedge clk) disable iff (!rs_n)
    (q_oe_o && !k_phase_o) |=> q_oe_o);

  // R3: output enable only turns on at a K edge
  assert_oe_rise_R3: assert property (@(posedge clk) disable iff (!rs_n)
    $rose(q_oe_o) |-> !k_phase_o);

  // R9: output enable only turns off at a K edge
  assert_oe_fall_R9: assert property (@(posedge clk) disable iff (!rs_n)
    $fell(q_oe_o) |-> !k_phase_o);

  // R4: the deferred register first fills at a K# edge
  assert_post_fill_R4: assert property (@(posedge clk) disable iff (!rs_n)
    $rose(post_v) |-> k_phase_o);
endmodule

bind ddr2w_sram ddr2w_sram_chk u_chk (
  .clk(clk), .rs_n(rs_n), .k_phase_o(k_phase_o), .q_oe_o(q_oe_o), .post_v(post_v)
);

// File: tb/ddr2w_sram_test.sv
`timescale 1ns/1ps
module ddr2w_sram_test;
  localparam int AW = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, ld_n, rw;
  logic [AW-1:0] addr;
  logic [17:0]   d;
  logic [1:0]    bw_n;
  logic [17:0]   q;
  logic          oe, kph;

  ddr2w_sram #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ld_n_i(ld_n), .rw_i(rw), .addr_i(addr),
    .d_i(d), .bw_n_i(bw_n), .k_phase_o(kph), .q_o(q), .q_oe_o(oe)
  );

  int    checks = 0, errors = 0, e = 0;
  string tag = "R1";
  bit    done = 0, started = 0, last_k = 0;

  logic [35:0] ref_mem [int];
  int          rd_due [int];
  int          w0_due [int];
  int          w1_due [int];
  logic [17:0] t_d0 [int];
  logic [1:0]  t_be0 [int];
  logic [17:0] exp_q [int];
  bit          exp_oe [int];
  logic [17:0] drv_d [int];
  logic [1:0]  drv_bw [int];

  task automatic check(input bit ok, input string what, input logic [35:0] act, input logic [35:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Reference: writes land when their second word arrives; reads take the line when word 0 is due.
  task automatic model(input bit kedge);
    logic [35:0] l, nl;
    logic [3:0]  be;
    if (rd_due.exists(e)) begin
      l = ref_mem.exists(rd_due[e]) ? ref_mem[rd_due[e]] : 'x;
      exp_q[e] = l[17:0];  exp_q[e+1] = l[35:18];
      exp_oe[e] = 1;       exp_oe[e+1] = 1;
    end
    if (w0_due.exists(e)) begin
      w1_due[e+1] = w0_due[e];
      t_d0[e+1]   = d;
      t_be0[e+1]  = ~bw_n;
    end
    if (w1_due.exists(e)) begin
      nl = {d, t_d0[e]};
      be = {~bw_n, t_be0[e]};
      l  = ref_mem.exists(w1_due[e]) ? ref_mem[w1_due[e]] : 'x;
      for (int i = 0; i < 4; i++) if (be[i]) l[i*9 +: 9] = nl[i*9 +: 9];
      ref_mem[w1_due[e]] = l;
    end
    if (kedge && !ld_n) begin
      if (rw) rd_due[e+4] = int'(addr);
      else    w0_due[e+2] = int'(addr);
    end
  endtask

  task automatic step(input bit c_ld_n, input bit c_rw, input logic [AW-1:0] c_a);
    bit kedge, eo;
    kedge = kph;
    ld_n = c_ld_n;  rw = c_rw;  addr = c_a;
    d    = drv_d.exists(e)  ? drv_d[e]  : 18'($urandom);
    bw_n = drv_bw.exists(e) ? drv_bw[e] : 2'($urandom);
    if (started) check(kedge != last_k, "phase alternation R2", {35'd0, kedge}, {35'd0, ~last_k});
    last_k  = kedge;
    started = 1;
    model(kedge);
    @(negedge clk);
    eo = exp_oe.exists(e) ? exp_oe[e] : 1'b0;
    check(oe === eo, "q_oe", {35'd0, oe}, {35'd0, eo});
    if (eo) check(q === exp_q[e], "q word", {18'd0, q}, {18'd0, exp_q[e]});
    e++;
  endtask

  task automatic align();
    while (kph !== 1'b1) step(1'b1, 1'b0, '0);
  endtask

  // The K# edge of each call carries a random command that must be ignored (R2).
  task automatic wr(input logic [AW-1:0] a, input logic [17:0] d0, input logic [17:0] d1,
                    input logic [1:0] b0n, input logic [1:0] b1n);
    align();
    drv_d[e+2] = d0;  drv_bw[e+2] = b0n;
    drv_d[e+3] = d1;  drv_bw[e+3] = b1n;
    step(1'b0, 1'b0, a);
    step(1'($urandom), 1'($urandom), AW'($urandom));
  endtask

  task automatic rd(input logic [AW-1:0] a);
    align();
    step(1'b0, 1'b1, a);
    step(1'($urandom), 1'($urandom), AW'($urandom));
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) begin
      align();
      step(1'b1, 1'b0, '0);
      step(1'b1, 1'b0, '0);
    end
  endtask

  initial begin
    rst_n = 1'b0;  ld_n = 1'b1;  rw = 1'b0;  addr = '0;  d = '0;  bw_n = 2'b11;
    repeat (3) @(negedge clk);
    tag = "R1";
    check(oe === 1'b0, "q_oe in reset R1", {35'd0, oe}, 36'd0);
    check(kph === 1'b1, "k_phase in reset R1", {35'd0, kph}, 36'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    tag = "R4";                                       // back-to-back full writes fill every line
    for (int a = 0; a < 64; a++) wr(AW'(a), 18'(a * 1234 + 7), 18'(a * 777 + 3), 2'b00, 2'b00);
    nop(3);

    tag = "R3";
    rd(5);
    nop(3);

    tag = "R6";                                       // streaming reads, then mixed traffic
    for (int a = 10; a < 22; a++) rd(AW'(a));
    for (int a = 40; a < 46; a++) begin
      wr(AW'(a), 18'($urandom), 18'($urandom), 2'b00, 2'b00);
      rd(AW'(a - 30));
    end
    nop(3);

    tag = "R5";                                       // per-byte selects, active low
    wr(7, 18'h3ffff, 18'h2aaaa, 2'b10, 2'b01);
    wr(8, 18'h15555, 18'h0f0f0, 2'b11, 2'b00);
    wr(9, 18'h12345, 18'h0abcd, 2'b01, 2'b11);
    nop(2);
    rd(7);  rd(8);  rd(9);
    nop(3);

    tag = "R7";                                       // read straight after a write to the same line
    wr(30, 18'h11111, 18'h22222, 2'b00, 2'b00);
    rd(30);
    wr(31, 18'h33333, 18'h04444, 2'b00, 2'b10);
    rd(31);
    nop(3);

    tag = "R8";                                       // deferred line survives intervening reads
    wr(33, 18'h0dead, 18'h0beef, 2'b00, 2'b00);
    rd(1);  rd(2);  rd(3);  rd(33);
    nop(3);

    tag = "R10";                                      // commit of the deferred line by a newer write
    wr(34, 18'h1cafe, 18'h2f00d, 2'b00, 2'b00);
    rd(34);
    wr(35, 18'h00aa5, 18'h3c3c3, 2'b00, 2'b00);
    rd(34);
    wr(34, 18'h3ffff, 18'h00000, 2'b01, 2'b10);
    wr(36, 18'h01010, 18'h02020, 2'b00, 2'b00);
    rd(34);  rd(35);  rd(36);
    nop(3);

    tag = "R2";                                       // commands on K# edges only: no effect
    for (int i = 0; i < 8; i++) begin
      align();
      step(1'b1, 1'b0, '0);
      step(1'b0, 1'(i % 2), AW'(50 + i));
    end
    nop(3);
    rd(50);  rd(51);
    nop(3);

    tag = "R9";                                       // output released after the last pending burst
    rd(3);  rd(4);
    nop(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog %s actual=hung expected=done", tag);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule